// File: doc/BRIEF.md
# Hardware System-Call Emulation Trap

This block sits beside the execute stage of a small 32-bit scalar core and emulates a bounded set of operating-system calls directly in hardware. When the executing instruction is a system-call instruction, the block reads the call number from general register 3 and compares the full 32-bit value against a parameter table of eleven supported codes. A match is serviced in one registered step. The block zeroes general register 2 and the matching 128-bit shadow register entry, moves the program counter on by one word, and pulses retire. The control state stays in its fetch-request state.

An unsupported call number, or any other instruction that the rest of the core reports it cannot execute, stops the core. The block records the program counter and the raw instruction word of the first such failure and then ignores all further work until reset. For test observation it keeps a saturating retire counter. For each supported code it also keeps a seen flag, a saturating call count, the program counter of the first call and the four argument registers captured at that first call. Any one entry can be read through a registered select port.

Top module: `sys_trap_unit`

## Requirements
- R1: An instruction is a system call when bits [31:26] are 0 and bits [5:0] are 0x0C. Its call number is the full 32-bit value of register 3 (`rs_v1`), compared exactly against every table entry. With the default table, 0xFFFF_FFBD matches and 0x0000_00BD, 0x8000_006B and 0xFFFF_FF6B do not.
- R2: One cycle after a supported call, `gpr_we` is 1 with `gpr_waddr` = 2 and `gpr_wdata` = 0. In the same cycle `shd_we` is 1 with `shd_waddr` = 2 and `shd_wdata` = 0 (128 bits).
- R3: For a supported call, `retire_pulse` and `pc_load` are high for exactly one cycle, with `pc_next` equal to the call's PC plus 4. `fetch_req` stays 1.
- R4: An unsupported call number sets `halted` one cycle later, with no retire and no writeback. It also latches `halt_pc` and `halt_instr` and sets `halt_cause` to 1.
- R5: A valid non-system-call instruction with `ex_other_ok` = 0 halts the core in the same way with `halt_cause` = 0. With `ex_other_ok` = 1 it has no effect on any output.
- R6: Once halted, `halted` stays 1 and `fetch_req` stays 0 until reset. Further instructions cause no retire, no writeback and no change to the latched diagnostics, the counters or the per-code records.
- R7: `retire_count` rises by one with each retire pulse and holds at its all-ones value.
- R8: Each supported code's record holds a seen flag and a call count that holds at its all-ones value. It also holds the PC and arguments `rs_a0`..`rs_a3` taken from the first call only. The records are indexed by table position, where entry 0 is the least significant 32 bits of `CODE_TABLE`.
- R9: `obs_sel` selects a record, and the selected record appears on the `obs_*` outputs one cycle later. A select at or beyond the table size reads as all zeros.
- R10: A synchronous active-high `rst` clears every register. After reset, `fetch_req` = 1, `halted` = 0, all counts are 0 and all records are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_valid | input | 1 | An instruction is executing this cycle |
| ex_pc | input | 32 | PC of the executing instruction |
| ex_instr | input | 32 | Raw instruction word |
| ex_other_ok | input | 1 | Rest of core executes this non-system-call instruction |
| rs_v1 | input | 32 | Register 3 value (call number) |
| rs_a0 | input | 32 | Register 4 value |
| rs_a1 | input | 32 | Register 5 value |
| rs_a2 | input | 32 | Register 6 value |
| rs_a3 | input | 32 | Register 7 value |
| obs_sel | input | IDX_W | Record select for observation |
| fetch_req | output | 1 | Control is in fetch-request state |
| retire_pulse | output | 1 | One-cycle retire of an emulated call |
| pc_load | output | 1 | Load `pc_next` into the PC |
| pc_next | output | 32 | Next PC after an emulated call |
| gpr_we | output | 1 | Scalar register write enable |
| gpr_waddr | output | 5 | Scalar register write index |
| gpr_wdata | output | 32 | Scalar register write data |
| shd_we | output | 1 | Shadow register write enable |
| shd_waddr | output | 5 | Shadow register write index |
| shd_wdata | output | 128 | Shadow register write data |
| halted | output | 1 | Core stopped |
| halt_cause | output | 1 | 1 = unsupported call, 0 = unsupported instruction |
| halt_pc | output | 32 | PC of the first failure |
| halt_instr | output | 32 | Instruction word of the first failure |
| retire_count | output | RET_W | Saturating retire counter |
| obs_seen | output | 1 | Selected code has been called |
| obs_count | output | CNT_W | Saturating call count of selected code |
| obs_first_pc | output | 32 | PC of first call of selected code |
| obs_a0 | output | 32 | First-call argument 0 |
| obs_a1 | output | 32 | First-call argument 1 |
| obs_a2 | output | 32 | First-call argument 2 |
| obs_a3 | output | 32 | First-call argument 3 |

## Verification
The hardest states to reach are the two saturation limits and the full-width code comparison, because each call that fails the table ends the run. The bench therefore uses narrow count widths. It loops calls on one code and on the whole table until both the per-code count and the retire counter stick at their maxima. The sweep then resets before every single call number from 0 to 0x7F and before several values that agree with a table entry only in their low byte, so each value is classified from a fresh core. A halt is also provoked first and followed by a legal call, to show that nothing moves afterwards.

// File: rtl/sys_trap_pkg.sv
package sys_trap_pkg;

  localparam logic [5:0] OPC_SPECIAL = 6'h00;
  localparam logic [5:0] FN_SYSCALL  = 6'h0C;
  localparam logic [4:0] GPR_RESULT  = 5'd2;

  typedef enum logic {
    ST_FETCH = 1'b0,
    ST_HALT  = 1'b1
  } ctl_state_e;

  typedef enum logic {
    CAUSE_OPCODE  = 1'b0,
    CAUSE_SYSCALL = 1'b1
  } halt_cause_e;

  typedef struct packed {
    logic [31:0] a0;
    logic [31:0] a1;
    logic [31:0] a2;
    logic [31:0] a3;
  } arg_set_t;

endpackage

// File: rtl/code_match.sv
module code_match #(
  parameter int NUM_CODES = 11,
  parameter logic [NUM_CODES*32-1:0] CODE_TABLE = '0,
  localparam int IDX_W = (NUM_CODES > 1) ? $clog2(NUM_CODES) : 1
) (
  input  logic [31:0]      code,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  logic [NUM_CODES-1:0] match;

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_cmp
    assign match[g] = (code == CODE_TABLE[g*32 +: 32]);
  end

  // lowest table position wins if an entry is duplicated
  always_comb begin
    idx = '0;
    for (int i = NUM_CODES - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end

  assign hit = |match;

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst)                   q <= '0;
    else if (inc && q != TOP)  q <= q + 1'b1;
  end

endmodule

// File: rtl/obs_bank.sv
module obs_bank
  import sys_trap_pkg::*;
#(
  parameter int NUM_CODES = 11,
  parameter int CNT_W     = 16,
  localparam int IDX_W = (NUM_CODES > 1) ? $clog2(NUM_CODES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [31:0]      upd_pc,
  input  arg_set_t         upd_args,
  input  logic [IDX_W-1:0] obs_sel,
  output logic             obs_seen,
  output logic [CNT_W-1:0] obs_count,
  output logic [31:0]      obs_first_pc,
  output arg_set_t         obs_args
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic             seen_q  [NUM_CODES];
  logic [CNT_W-1:0] cnt_q   [NUM_CODES];
  logic [31:0]      fpc_q   [NUM_CODES];
  arg_set_t         args_q  [NUM_CODES];

  // record update: count always, capture only on first call
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CODES; i++) begin
        seen_q[i] <= 1'b0;
        cnt_q[i]  <= '0;
        fpc_q[i]  <= '0;
        args_q[i] <= '0;
      end
    end else if (upd_en) begin
      for (int i = 0; i < NUM_CODES; i++) begin
        if (upd_idx == IDX_W'(i)) begin
          seen_q[i] <= 1'b1;
          if (cnt_q[i] != CNT_TOP) cnt_q[i] <= cnt_q[i] + 1'b1;
          if (!seen_q[i]) begin
            fpc_q[i]  <= upd_pc;
            args_q[i] <= upd_args;
          end
        end
      end
    end
  end

  // registered read port; out-of-range select reads zero
  always_ff @(posedge clk) begin
    if (rst) begin
      obs_seen     <= 1'b0;
      obs_count    <= '0;
      obs_first_pc <= '0;
      obs_args     <= '0;
    end else begin
      obs_seen     <= 1'b0;
      obs_count    <= '0;
      obs_first_pc <= '0;
      obs_args     <= '0;
      for (int i = 0; i < NUM_CODES; i++) begin
        if (obs_sel == IDX_W'(i)) begin
          obs_seen     <= seen_q[i];
          obs_count    <= cnt_q[i];
          obs_first_pc <= fpc_q[i];
          obs_args     <= args_q[i];
        end
      end
    end
  end

endmodule

// File: rtl/sys_trap_unit.sv
module sys_trap_unit
  import sys_trap_pkg::*;
#(
  parameter int NUM_CODES = 11,
  parameter logic [NUM_CODES*32-1:0] CODE_TABLE = {
    32'hFFFF_FFBD, 32'h0000_007A, 32'h0000_0078, 32'h0000_0077,
    32'h0000_0076, 32'h0000_006B, 32'h0000_0064, 32'h0000_0044,
    32'h0000_0040, 32'h0000_003D, 32'h0000_003C},
  parameter int CNT_W = 16,
  parameter int RET_W = 32,
  localparam int IDX_W = (NUM_CODES > 1) ? $clog2(NUM_CODES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ex_valid,
  input  logic [31:0]        ex_pc,
  input  logic [31:0]        ex_instr,
  input  logic               ex_other_ok,
  input  logic [31:0]        rs_v1,
  input  logic [31:0]        rs_a0,
  input  logic [31:0]        rs_a1,
  input  logic [31:0]        rs_a2,
  input  logic [31:0]        rs_a3,
  input  logic [IDX_W-1:0]   obs_sel,
  output logic               fetch_req,
  output logic               retire_pulse,
  output logic               pc_load,
  output logic [31:0]        pc_next,
  output logic               gpr_we,
  output logic [4:0]         gpr_waddr,
  output logic [31:0]        gpr_wdata,
  output logic               shd_we,
  output logic [4:0]         shd_waddr,
  output logic [127:0]       shd_wdata,
  output logic               halted,
  output logic               halt_cause,
  output logic [31:0]        halt_pc,
  output logic [31:0]        halt_instr,
  output logic [RET_W-1:0]   retire_count,
  output logic               obs_seen,
  output logic [CNT_W-1:0]   obs_count,
  output logic [31:0]        obs_first_pc,
  output logic [31:0]        obs_a0,
  output logic [31:0]        obs_a1,
  output logic [31:0]        obs_a2,
  output logic [31:0]        obs_a3
);

  ctl_state_e       state_q;
  logic             is_sys;
  logic             live;
  logic             code_hit;
  logic [IDX_W-1:0] code_idx;
  logic             take_call;
  logic             bad_call;
  logic             bad_op;
  arg_set_t         cur_args;
  arg_set_t         rd_args;

  assign is_sys    = (ex_instr[31:26] == OPC_SPECIAL) && (ex_instr[5:0] == FN_SYSCALL);
  assign live      = ex_valid && (state_q == ST_FETCH);
  assign take_call = live && is_sys && code_hit;
  assign bad_call  = live && is_sys && !code_hit;
  assign bad_op    = live && !is_sys && !ex_other_ok;
  assign cur_args  = '{a0: rs_a0, a1: rs_a1, a2: rs_a2, a3: rs_a3};

  code_match #(
    .NUM_CODES  (NUM_CODES),
    .CODE_TABLE (CODE_TABLE)
  ) u_match (
    .code (rs_v1),
    .hit  (code_hit),
    .idx  (code_idx)
  );

  // control state, writeback and diagnostics
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_FETCH;
      retire_pulse <= 1'b0;
      pc_load      <= 1'b0;
      pc_next      <= '0;
      gpr_we       <= 1'b0;
      gpr_waddr    <= '0;
      gpr_wdata    <= '0;
      shd_we       <= 1'b0;
      shd_waddr    <= '0;
      shd_wdata    <= '0;
      halt_cause   <= CAUSE_OPCODE;
      halt_pc      <= '0;
      halt_instr   <= '0;
    end else begin
      retire_pulse <= 1'b0;
      pc_load      <= 1'b0;
      gpr_we       <= 1'b0;
      shd_we       <= 1'b0;
      if (take_call) begin
        retire_pulse <= 1'b1;
        pc_load      <= 1'b1;
        pc_next      <= ex_pc + 32'd4;
        gpr_we       <= 1'b1;
        gpr_waddr    <= GPR_RESULT;
        gpr_wdata    <= '0;
        shd_we       <= 1'b1;
        shd_waddr    <= GPR_RESULT;
        shd_wdata    <= '0;
        state_q      <= ST_FETCH;
      end else if (bad_call || bad_op) begin
        state_q    <= ST_HALT;
        halt_cause <= bad_call ? CAUSE_SYSCALL : CAUSE_OPCODE;
        halt_pc    <= ex_pc;
        halt_instr <= ex_instr;
      end
    end
  end

  assign fetch_req = (state_q == ST_FETCH);
  assign halted    = (state_q == ST_HALT);

  sat_counter #(.W(RET_W)) u_retire_ctr (
    .clk (clk),
    .rst (rst),
    .inc (take_call),
    .q   (retire_count)
  );

  obs_bank #(
    .NUM_CODES (NUM_CODES),
    .CNT_W     (CNT_W)
  ) u_obs (
    .clk          (clk),
    .rst          (rst),
    .upd_en       (take_call),
    .upd_idx      (code_idx),
    .upd_pc       (ex_pc),
    .upd_args     (cur_args),
    .obs_sel      (obs_sel),
    .obs_seen     (obs_seen),
    .obs_count    (obs_count),
    .obs_first_pc (obs_first_pc),
    .obs_args     (rd_args)
  );

  assign obs_a0 = rd_args.a0;
  assign obs_a1 = rd_args.a1;
  assign obs_a2 = rd_args.a2;
  assign obs_a3 = rd_args.a3;

endmodule

// File: rtl/sys_trap_chk.sv
module sys_trap_chk #(
  parameter int RET_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [31:0]      ex_pc,
  input logic             retire_pulse,
  input logic             pc_load,
  input logic [31:0]      pc_next,
  input logic             gpr_we,
  input logic [4:0]       gpr_waddr,
  input logic [31:0]      gpr_wdata,
  input logic             shd_we,
  input logic [127:0]     shd_wdata,
  input logic             halted,
  input logic [31:0]      halt_pc,
  input logic [31:0]      halt_instr,
  input logic [RET_W-1:0] retire_count
);

  localparam logic [RET_W-1:0] RET_TOP = '1;

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assert_wb_zero_R2: assert property (@(posedge clk) disable iff (rst)
    gpr_we |-> (gpr_waddr == 5'd2 && gpr_wdata == 32'd0 && shd_we && shd_wdata == 128'd0));

  assert_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && retire_pulse) |-> (pc_load && pc_next == $past(ex_pc) + 32'd4));

  assert_halt_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!retire_pulse && !gpr_we && !shd_we));

  assert_halt_pc_R4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $rose(halted)) |-> (halt_pc == $past(ex_pc)));

  assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  assert_diag_hold_R6: assert property (@(posedge clk) disable iff (rst)
    halted |=> ($stable(halt_pc) && $stable(halt_instr)));

  assert_ret_inc_R7: assert property (@(posedge clk) disable iff (rst)
    (past_ok && retire_pulse && $past(retire_count) != RET_TOP)
      |-> (retire_count == $past(retire_count) + 1'b1));

  assert_ret_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !retire_pulse) |-> $stable(retire_count));

endmodule

bind sys_trap_unit sys_trap_chk #(.RET_W(RET_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ex_pc        (ex_pc),
  .retire_pulse (retire_pulse),
  .pc_load      (pc_load),
  .pc_next      (pc_next),
  .gpr_we       (gpr_we),
  .gpr_waddr    (gpr_waddr),
  .gpr_wdata    (gpr_wdata),
  .shd_we       (shd_we),
  .shd_wdata    (shd_wdata),
  .halted       (halted),
  .halt_pc      (halt_pc),
  .halt_instr   (halt_instr),
  .retire_count (retire_count)
);

// File: tb/sys_trap_unit_tb_top.sv
module sys_trap_unit_tb_top;

  localparam int NC    = 11;
  localparam int CW    = 2;
  localparam int RW    = 4;
  localparam int IW    = 4;
  localparam logic [NC*32-1:0] TBL = {
    32'hFFFF_FFBD, 32'h0000_007A, 32'h0000_0078, 32'h0000_0077,
    32'h0000_0076, 32'h0000_006B, 32'h0000_0064, 32'h0000_0044,
    32'h0000_0040, 32'h0000_003D, 32'h0000_003C};
  localparam logic [31:0] SYSCALL_W = 32'h0000_000C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ex_valid = 1'b0, ex_other_ok = 1'b0;
  logic [31:0] ex_pc = '0, ex_instr = '0, rs_v1 = '0;
  logic [31:0] rs_a0 = '0, rs_a1 = '0, rs_a2 = '0, rs_a3 = '0;
  logic [IW-1:0] obs_sel = '0;
  logic fetch_req, retire_pulse, pc_load, gpr_we, shd_we, halted, halt_cause, obs_seen;
  logic [31:0] pc_next, gpr_wdata, halt_pc, halt_instr, obs_first_pc;
  logic [31:0] obs_a0, obs_a1, obs_a2, obs_a3;
  logic [4:0] gpr_waddr, shd_waddr;
  logic [127:0] shd_wdata;
  logic [RW-1:0] retire_count;
  logic [CW-1:0] obs_count;

  int n_chk = 0, n_fail = 0;
  int calls [NC];
  int total;

  always #2.5 clk = ~clk;

  sys_trap_unit #(.NUM_CODES(NC), .CODE_TABLE(TBL), .CNT_W(CW), .RET_W(RW)) dut_i (
    .clk(clk), .rst(rst), .ex_valid(ex_valid), .ex_pc(ex_pc), .ex_instr(ex_instr),
    .ex_other_ok(ex_other_ok), .rs_v1(rs_v1), .rs_a0(rs_a0), .rs_a1(rs_a1),
    .rs_a2(rs_a2), .rs_a3(rs_a3), .obs_sel(obs_sel), .fetch_req(fetch_req),
    .retire_pulse(retire_pulse), .pc_load(pc_load), .pc_next(pc_next),
    .gpr_we(gpr_we), .gpr_waddr(gpr_waddr), .gpr_wdata(gpr_wdata),
    .shd_we(shd_we), .shd_waddr(shd_waddr), .shd_wdata(shd_wdata),
    .halted(halted), .halt_cause(halt_cause), .halt_pc(halt_pc),
    .halt_instr(halt_instr), .retire_count(retire_count), .obs_seen(obs_seen),
    .obs_count(obs_count), .obs_first_pc(obs_first_pc), .obs_a0(obs_a0),
    .obs_a1(obs_a1), .obs_a2(obs_a2), .obs_a3(obs_a3));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic int find_code(input logic [31:0] v);
    for (int i = 0; i < NC; i++) if (TBL[i*32 +: 32] == v) return i;
    return -1;
  endfunction

  function automatic logic [31:0] arg_of(input int k, input int j);
    return 32'hA000_0000 + 32'(k * 16 + j);
  endfunction

  task automatic do_reset();
    rst = 1'b1; ex_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic issue(input logic [31:0] pc, input logic [31:0] ins,
                       input logic [31:0] v1, input logic ok, input int k);
    ex_valid = 1'b1; ex_pc = pc; ex_instr = ins; rs_v1 = v1; ex_other_ok = ok;
    rs_a0 = arg_of(k, 0); rs_a1 = arg_of(k, 1); rs_a2 = arg_of(k, 2); rs_a3 = arg_of(k, 3);
    @(negedge clk);
    ex_valid = 1'b0;
  endtask

  task automatic good_call(input int k, input logic [31:0] pc);
    issue(pc, SYSCALL_W | 32'h0003_FFC0, TBL[k*32 +: 32], 1'b0, calls[k]);
    calls[k]++; total++;
    chk("R2 gpr_we", 32'(gpr_we), 1);
    chk("R2 gpr_waddr", 32'(gpr_waddr), 2);
    chk("R2 gpr_wdata", gpr_wdata, 0);
    chk("R2 shadow", 32'({shd_we, shd_waddr, shd_wdata == 128'd0}), 32'h45);
    chk("R3 retire_pulse", 32'(retire_pulse), 1);
    chk("R3 pc_next", pc_next, pc + 4);
    chk("R3 fetch_req", 32'(fetch_req), 1);
    chk("R7 retire_count", 32'(retire_count), (total > 15) ? 15 : total);
    @(negedge clk);
    chk("R3 one-cycle retire", 32'({retire_pulse, pc_load}), 0);
  endtask

  initial begin
    for (int i = 0; i < NC; i++) calls[i] = 0;
    total = 0;
    do_reset();
    // R10 reset state
    chk("R10 fetch_req", 32'(fetch_req), 1);
    chk("R10 halted", 32'(halted), 0);
    chk("R10 retire_count", 32'(retire_count), 0);
    chk("R10 retire_pulse", 32'(retire_pulse), 0);
    chk("R10 obs_seen", 32'(obs_seen), 0);

    // R2 R3 R7 R8: every code, then repeats to saturate both counters
    for (int k = 0; k < NC; k++) good_call(k, 32'h0010_0000 + 32'(k * 64));
    for (int r = 0; r < 4; r++) good_call(5, 32'h0020_0000 + 32'(r * 4));
    for (int r = 0; r < 3; r++) good_call(0, 32'h0030_0000 + 32'(r * 4));

    // R5: supported non-syscall instruction has no effect
    issue(32'h0040_0000, 32'h0062_102D, 32'h6B, 1'b1, 0);
    chk("R5 ok-op no retire", 32'({retire_pulse, gpr_we, shd_we, pc_load}), 0);
    chk("R5 ok-op not halted", 32'(halted), 0);
    chk("R5 ok-op count held", 32'(retire_count), 15);

    // R8 R9: read back every record and out-of-range selects
    for (int k = 0; k < 16; k++) begin
      obs_sel = IW'(k);
      @(negedge clk);
      if (k < NC) begin
        chk("R8 seen", 32'(obs_seen), 1);
        chk("R8 count", 32'(obs_count), (calls[k] > 3) ? 3 : calls[k]);
        chk("R8 first_pc", obs_first_pc, 32'h0010_0000 + 32'(k * 64));
        chk("R8 a0", obs_a0, arg_of(0, 0));
        chk("R8 a3", obs_a3, arg_of(0, 3));
      end else begin
        chk("R9 out-of-range zero",
            32'(obs_seen) | 32'(obs_count) | obs_first_pc | obs_a0 | obs_a1 | obs_a2 | obs_a3, 0);
      end
    end

    // R1 R4: sweep of call numbers, each from a fresh reset
    for (int v = 0; v < 132; v++) begin
      logic [31:0] code;
      int hit;
      case (v)
        128: code = 32'hFFFF_FFBD;
        129: code = 32'h0000_00BD;
        130: code = 32'h8000_006B;
        131: code = 32'hFFFF_FF6B;
        default: code = 32'(v);
      endcase
      hit = find_code(code);
      do_reset();
      issue(32'h0050_0000 + 32'(v * 4), SYSCALL_W, code, 1'b0, 1);
      if (hit >= 0) begin
        chk("R1 known code retires", 32'({retire_pulse, halted}), 32'h2);
      end else begin
        chk("R4 unknown code halts", 32'({retire_pulse, gpr_we, halted}), 32'h1);
        chk("R4 halt_cause", 32'(halt_cause), 1);
        chk("R4 halt_pc", halt_pc, 32'h0050_0000 + 32'(v * 4));
        chk("R4 halt_instr", halt_instr, SYSCALL_W);
      end
    end

    // R5 R6: unsupported opcode, then everything ignored
    do_reset();
    issue(32'h0011_0A60, 32'h0062_102F, 32'h6B, 1'b0, 2);
    chk("R5 opcode halts", 32'(halted), 1);
    chk("R5 halt_cause", 32'(halt_cause), 0);
    chk("R5 halt_pc", halt_pc, 32'h0011_0A60);
    chk("R5 halt_instr", halt_instr, 32'h0062_102F);
    issue(32'h0022_0000, SYSCALL_W, 32'h6B, 1'b0, 3);
    chk("R6 no retire", 32'({retire_pulse, gpr_we, shd_we, pc_load}), 0);
    issue(32'h0033_0000, 32'h0000_0000, 32'h0, 1'b0, 3);
    chk("R6 still halted", 32'({halted, fetch_req}), 32'h2);
    chk("R6 halt_pc held", halt_pc, 32'h0011_0A60);
    chk("R6 halt_instr held", halt_instr, 32'h0062_102F);
    chk("R6 retire_count held", 32'(retire_count), 0);
    obs_sel = IW'(5);
    @(negedge clk);
    chk("R6 record untouched", 32'({obs_seen, obs_count}), 0);

    // R10: reset releases halt
    do_reset();
    chk("R10 halt cleared", 32'({halted, fetch_req}), 32'h1);
    chk("R10 diag cleared", halt_pc | halt_instr, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule